// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits beside a small 8-bit CPU core and gathers interrupt events from five sources: two external request lines, two timer overflows, and one serial port. The serial port raises either of two conditions, transmit-buffer-empty or receive-buffer-full. Each of the six conditions latches its own pending flag from a single-cycle event pulse. Software controls the block through two byte-wide registers. The mask register holds a master switch and one enable bit per source. The level register gives each source either low or high priority.

When the CPU signals that it can take an interrupt, the block chooses one source. Any enabled high-level request beats every low-level request. Within a level, a fixed built-in order decides. The block raises a one-cycle request pulse and presents that source's fixed entry address. The CPU's acknowledge clears the chosen source's flag, except for the serial flags, which only software may clear. From issue until the return-from-interrupt strobe, no further interrupt is offered.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, all six pending flags are 0, both configuration registers are 0, `irq_req` is 0, `irq_vector` is 0 and `busy` is 0.
- R2: An event pulse sets its pending flag on the next clock edge. The flag stays 1 until it is cleared. `pend` bit order is [0] ext0, [1] tmr0, [2] ext1, [3] tmr1, [4] serial transmit, [5] serial receive.
- R3: A source can request only if its enable bit in the mask register is 1 and mask bit 7 (master switch) is 1. The enable bits are [0] ext0, [1] tmr0, [2] ext1, [3] tmr1, [4] serial. Mask bit 5 has no effect.
- R4: The level register uses the same bit positions as the mask register's low five bits, with 1 meaning high. An enabled high-level request is chosen ahead of any low-level request.
- R5: Among requests of the same level, the order from first to last is ext0, tmr0, ext1, tmr1, serial.
- R6: The presented vector is 0x0003 for ext0, 0x000B for tmr0, 0x0013 for ext1, 0x001B for tmr1 and 0x0023 for serial.
- R7: When idle with `cpu_ready` high and a request present, `irq_req` goes high for exactly one cycle on the next edge. The vector then holds until the strobe.
- R8: `irq_ack` clears the pending flag of the chosen non-serial source on the next edge.
- R9: Acknowledge never clears a serial flag. Only `sw_clr_tx` and `sw_clr_rx` clear them. An event and a clear of the same serial flag in one cycle leave it set.
- R10: From issue until `reti`, `busy` is 1 and no further `irq_req` occurs. After `reti`, a waiting request is issued on the second edge.
- R11: While `cpu_ready` is 0, no request is issued and flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext0_evt | input | 1 | External 0 event pulse |
| tmr0_evt | input | 1 | Timer 0 overflow pulse |
| ext1_evt | input | 1 | External 1 event pulse |
| tmr1_evt | input | 1 | Timer 1 overflow pulse |
| tx_evt | input | 1 | Serial transmit-empty pulse |
| rx_evt | input | 1 | Serial receive-full pulse |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask register write data |
| level_we | input | 1 | Level register write strobe |
| level_wdata | input | 8 | Level register write data |
| sw_clr_tx | input | 1 | Software clear of transmit flag |
| sw_clr_rx | input | 1 | Software clear of receive flag |
| cpu_ready | input | 1 | CPU can accept an interrupt |
| irq_ack | input | 1 | CPU acknowledge of the issued request |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | One-cycle interrupt request pulse |
| irq_vector | output | 16 | Entry address of the chosen source |
| busy | output | 1 | A request is issued or in service |
| pend | output | 6 | Pending flags |

## Verification
The bench fires all five sources together and serves them one after another. A wrong tie-break order would present the vectors out of sequence. A design that auto-cleared serial flags would drop the transmit flag at acknowledge. The bench raises a low-level and a high-level source at once, so a design ignoring the level register would vector to the external source first. It also injects events during service and with `cpu_ready` low. A design that failed to block would pulse `irq_req` early, and a lost flag would never be issued. A same-cycle serial event and clear catches a design that lets the clear win.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int SRC_N  = 5;
    localparam int FLAG_N = 6;

    localparam int IX_EXT0 = 0;
    localparam int IX_TMR0 = 1;
    localparam int IX_EXT1 = 2;
    localparam int IX_TMR1 = 3;
    localparam int IX_SER  = 4;
    localparam int IX_RX   = 5;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2,
        SQ_BUSY  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic             glb;
        logic [SRC_N-1:0] en;
        logic [SRC_N-1:0] lvl;
    } cfg_t;

    typedef struct packed {
        seq_state_e       st;
        logic [SRC_N-1:0] sel;
    } seq_t;
endpackage

// File: rtl/irqc_cfg.sv
module irqc_cfg
    import irqc_pkg::*;
#(
    parameter int CFG_W   = 8,
    parameter int GLB_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic [CFG_W-1:0] mask_wdata,
    input  logic             level_we,
    input  logic [CFG_W-1:0] level_wdata,
    output cfg_t             cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (mask_we) begin
            cfg_d.glb = mask_wdata[GLB_BIT];
            cfg_d.en  = mask_wdata[SRC_N-1:0];
        end
        if (level_we) begin
            cfg_d.lvl = level_wdata[SRC_N-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_we && !level_we) |=> $stable(cfg_q)); // R3
endmodule

// File: rtl/irqc_flags.sv
module irqc_flags
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_N-1:0] evt,
    input  logic [SRC_N-1:0]  ack_clr,
    input  logic              sw_clr_tx,
    input  logic              sw_clr_rx,
    output logic [FLAG_N-1:0] flags,
    output logic [SRC_N-1:0]  src_pend
);
    logic [FLAG_N-1:0] flags_d, flags_q;
    logic [FLAG_N-1:0] clr_vec;

    genvar gi;
    generate
        for (gi = 0; gi < FLAG_N; gi++) begin : g_clr
            if (gi < IX_SER) begin : g_auto
                assign clr_vec[gi] = ack_clr[gi];
            end else if (gi == IX_SER) begin : g_tx
                assign clr_vec[gi] = sw_clr_tx;
            end else begin : g_rx
                assign clr_vec[gi] = sw_clr_rx;
            end
        end
    endgenerate

    always_comb begin
        flags_d = evt | (flags_q & ~clr_vec);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags    = flags_q;
    assign src_pend = {flags_q[IX_SER] | flags_q[IX_RX], flags_q[IX_TMR1:IX_EXT0]};

    AST_SER_TX_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[IX_SER] && !sw_clr_tx) |=> flags_q[IX_SER]); // R9
    AST_SER_RX_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[IX_RX] && !sw_clr_rx) |=> flags_q[IX_RX]); // R9
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt[IX_EXT0] |=> flags_q[IX_EXT0]); // R2
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
(
    input  logic [SRC_N-1:0] src_pend,
    input  cfg_t             cfg,
    output logic [SRC_N-1:0] grant,
    output logic             any
);
    logic [SRC_N-1:0] req;
    logic [SRC_N-1:0] hi;
    logic [SRC_N-1:0] pick;

    genvar gi;
    generate
        for (gi = 0; gi < SRC_N; gi++) begin : g_req
            assign req[gi] = src_pend[gi] & cfg.en[gi] & cfg.glb;
            assign hi[gi]  = req[gi] & cfg.lvl[gi];
        end
    endgenerate

    always_comb begin
        logic taken;
        pick  = (|hi) ? hi : req;
        grant = '0;
        taken = 1'b0;
        for (int i = 0; i < SRC_N; i++) begin
            if (pick[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

    assign any = |req;

    always_comb begin
        AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R5
    end
endmodule

// File: rtl/irqc_seq.sv
module irqc_seq
    import irqc_pkg::*;
#(
    parameter int VEC_W      = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any,
    input  logic [SRC_N-1:0] grant,
    input  logic             cpu_ready,
    input  logic             irq_ack,
    input  logic             reti,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vector,
    output logic             busy,
    output logic [SRC_N-1:0] ack_clr
);
    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (any && cpu_ready) begin
                    s_d.st  = SQ_ISSUE;
                    s_d.sel = grant;
                end
            end
            SQ_ISSUE: s_d.st = irq_ack ? SQ_BUSY : SQ_WAIT;
            SQ_WAIT:  if (irq_ack) s_d.st = SQ_BUSY;
            SQ_BUSY: begin
                if (reti) begin
                    s_d.st  = SQ_IDLE;
                    s_d.sel = '0;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, sel: '0};
        else        s_q <= s_d;
    end

    always_comb begin
        irq_vector = '0;
        for (int i = 0; i < SRC_N; i++) begin
            if (s_q.sel[i]) irq_vector = VEC_W'(VEC_BASE + i * VEC_STRIDE);
        end
    end

    assign irq_req = (s_q.st == SQ_ISSUE);
    assign busy    = (s_q.st != SQ_IDLE);
    assign ack_clr = (irq_ack && (s_q.st == SQ_ISSUE || s_q.st == SQ_WAIT)) ? s_q.sel : '0;

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req); // R7
    AST_BLOCK_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SQ_BUSY && !reti) |=> !irq_req); // R10
    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !reti) |=> $stable(irq_vector)); // R7
    AST_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cpu_ready) |=> !irq_req); // R11
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqc_pkg::*;
#(
    parameter int CFG_W      = 8,
    parameter int GLB_BIT    = 7,
    parameter int VEC_W      = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext0_evt,
    input  logic              tmr0_evt,
    input  logic              ext1_evt,
    input  logic              tmr1_evt,
    input  logic              tx_evt,
    input  logic              rx_evt,
    input  logic              mask_we,
    input  logic [CFG_W-1:0]  mask_wdata,
    input  logic              level_we,
    input  logic [CFG_W-1:0]  level_wdata,
    input  logic              sw_clr_tx,
    input  logic              sw_clr_rx,
    input  logic              cpu_ready,
    input  logic              irq_ack,
    input  logic              reti,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vector,
    output logic              busy,
    output logic [FLAG_N-1:0] pend
);
    cfg_t              cfg;
    logic [FLAG_N-1:0] evt;
    logic [SRC_N-1:0]  src_pend;
    logic [SRC_N-1:0]  grant;
    logic              any;
    logic [SRC_N-1:0]  ack_clr;

    assign evt = {rx_evt, tx_evt, tmr1_evt, ext1_evt, tmr0_evt, ext0_evt};

    irqc_cfg #(.CFG_W(CFG_W), .GLB_BIT(GLB_BIT)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .level_we   (level_we),
        .level_wdata(level_wdata),
        .cfg        (cfg)
    );

    irqc_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .ack_clr  (ack_clr),
        .sw_clr_tx(sw_clr_tx),
        .sw_clr_rx(sw_clr_rx),
        .flags    (pend),
        .src_pend (src_pend)
    );

    irqc_arbiter u_arb (
        .src_pend(src_pend),
        .cfg     (cfg),
        .grant   (grant),
        .any     (any)
    );

    irqc_seq #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .any       (any),
        .grant     (grant),
        .cpu_ready (cpu_ready),
        .irq_ack   (irq_ack),
        .reti      (reti),
        .irq_req   (irq_req),
        .irq_vector(irq_vector),
        .busy      (busy),
        .ack_clr   (ack_clr)
    );

    AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.glb && !busy) |=> !irq_req); // R3
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr[IX_TMR0] && !tmr0_evt) |=> !pend[IX_TMR0]); // R8
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext0_evt = 0, tmr0_evt = 0, ext1_evt = 0, tmr1_evt = 0, tx_evt = 0, rx_evt = 0;
    logic mask_we = 0, level_we = 0;
    logic [7:0] mask_wdata = '0, level_wdata = '0;
    logic sw_clr_tx = 0, sw_clr_rx = 0, cpu_ready = 1, irq_ack = 0, reti = 0;
    logic irq_req, busy;
    logic [15:0] irq_vector;
    logic [5:0] pend;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    irq_vector_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .ext0_evt(ext0_evt), .tmr0_evt(tmr0_evt), .ext1_evt(ext1_evt),
        .tmr1_evt(tmr1_evt), .tx_evt(tx_evt), .rx_evt(rx_evt),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .level_we(level_we), .level_wdata(level_wdata),
        .sw_clr_tx(sw_clr_tx), .sw_clr_rx(sw_clr_rx),
        .cpu_ready(cpu_ready), .irq_ack(irq_ack), .reti(reti),
        .irq_req(irq_req), .irq_vector(irq_vector), .busy(busy), .pend(pend)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_mask(input logic [7:0] v);
        mask_we = 1; mask_wdata = v; step(1); mask_we = 0;
    endtask

    task automatic set_level(input logic [7:0] v);
        level_we = 1; level_wdata = v; step(1); level_we = 0;
    endtask

    // wait for the request pulse, check vector, acknowledge
    task automatic take(input string tag, input logic [15:0] vec);
        int waited = 0;
        while (!irq_req && waited < 8) begin
            step(1); waited++;
        end
        check({tag, " R7 req"}, irq_req, 1);
        check({tag, " R6 vector"}, irq_vector, vec);
        irq_ack = 1; step(1); irq_ack = 0;
        check({tag, " R7 pulse ends"}, irq_req, 0);
        check({tag, " R10 busy"}, busy, 1);
    endtask

    task automatic ret();
        reti = 1; step(1); reti = 0;
    endtask

    task automatic t_reset();
        check("R1 pend", pend, 0);
        check("R1 req", irq_req, 0);
        check("R1 vector", irq_vector, 0);
        check("R1 busy", busy, 0);
    endtask

    task automatic t_single();
        set_mask(8'h81);
        ext0_evt = 1; step(1); ext0_evt = 0;
        check("R2 ext0 set", pend[0], 1);
        step(1);
        check("R7 ext0 issued", irq_req, 1);
        take("ext0", 16'h0003);
        check("R8 ext0 cleared", pend[0], 0);
        ret();
        step(2);
        check("R10 idle after reti", busy, 0);
    endtask

    task automatic t_masks();
        set_mask(8'h01);
        ext0_evt = 1; step(1); ext0_evt = 0;
        step(4);
        check("R3 master off no req", busy, 0);
        check("R2 flag held", pend[0], 1);
        set_mask(8'ha1);
        take("R3 master on", 16'h0003);
        ret();
        set_mask(8'h81);
        tmr0_evt = 1; step(1); tmr0_evt = 0;
        step(4);
        check("R3 tmr0 disabled", busy, 0);
        check("R3 tmr0 pend", pend[1], 1);
        set_mask(8'h83);
        take("R3 tmr0 enabled", 16'h000b);
        check("R8 tmr0 cleared", pend[1], 0);
        ret();
    endtask

    task automatic t_order();
        set_mask(8'h9f);
        cpu_ready = 0;
        ext0_evt = 1; tmr0_evt = 1; ext1_evt = 1; tmr1_evt = 1; tx_evt = 1;
        step(1);
        ext0_evt = 0; tmr0_evt = 0; ext1_evt = 0; tmr1_evt = 0; tx_evt = 0;
        step(3);
        check("R11 held off", busy, 0);
        check("R11 flags kept", pend, 6'h1f);
        cpu_ready = 1;
        take("R5 first", 16'h0003); ret();
        take("R5 second", 16'h000b); ret();
        take("R5 third", 16'h0013); ret();
        take("R5 fourth", 16'h001b); ret();
        take("R5 serial", 16'h0023);
        check("R9 tx kept after ack", pend[4], 1);
        sw_clr_tx = 1; step(1); sw_clr_tx = 0;
        check("R9 tx cleared by sw", pend[4], 0);
        ret();
    endtask

    task automatic t_level();
        set_level(8'h08);
        cpu_ready = 0;
        ext0_evt = 1; tmr1_evt = 1; step(1); ext0_evt = 0; tmr1_evt = 0;
        cpu_ready = 1;
        take("R4 high first", 16'h001b); ret();
        take("R4 low next", 16'h0003); ret();
        set_level(8'h00);
    endtask

    task automatic t_block();
        ext1_evt = 1; step(1); ext1_evt = 0;
        take("R10 first", 16'h0013);
        tmr0_evt = 1; step(1); tmr0_evt = 0;
        for (int i = 0; i < 4; i++) begin
            check("R10 no req while busy", irq_req, 0);
            step(1);
        end
        ret();
        check("R10 not yet", irq_req, 0);
        step(1);
        check("R10 issue after reti", irq_req, 1);
        take("R10 waiting", 16'h000b); ret();
    endtask

    task automatic t_serial();
        set_mask(8'h80);
        rx_evt = 1; step(1); rx_evt = 0;
        check("R2 rx set", pend[5], 1);
        rx_evt = 1; sw_clr_rx = 1; step(1); rx_evt = 0; sw_clr_rx = 0;
        check("R9 set wins over clear", pend[5], 1);
        sw_clr_rx = 1; step(1); sw_clr_rx = 0;
        check("R9 rx cleared", pend[5], 0);
        set_mask(8'h90);
        rx_evt = 1; step(1); rx_evt = 0;
        take("R6 rx serial", 16'h0023);
        check("R9 rx kept after ack", pend[5], 1);
        sw_clr_rx = 1; step(1); sw_clr_rx = 0;
        ret();
        step(2);
        check("R9 idle after clear", busy, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        t_reset();
        t_single();
        t_masks();
        t_order();
        t_level();
        t_block();
        t_serial();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule